// File: doc/BRIEF.md
# Burst Re-arbitration Point Generator

This block sits beside the arbiter of one slave port on an AHB-style interconnect. It watches the transfer type, burst type and ready signal of whichever master currently owns the port. It raises a one-cycle pulse whenever ownership may safely be handed to another master. Three events can produce such a point:

- the closing beat of a burst whose length is fixed;
- a configurable beat boundary inside an open-ended (INCR) burst;
- a per-slave cycle budget that, once spent, lets the next completed beat end the access.

The arbiter supplies the current master's burst-limit code and the slave's cycle budget as plain inputs. It then treats a high `arb_point` as permission to pick a new owner. The pulse is registered, so it describes the bus cycle just before it.

Top module: `rearb_point_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `arb_point` is 0.
- R2: A cycle with `htrans` = 0 (idle) makes `arb_point` high in the following cycle.
- R3: A cycle that is not idle and completes no beat gives no point. Such a cycle is `htrans` = 1 (busy), or `htrans` = 2/3 with `hready` low. A completed beat is `htrans` = 2 (NONSEQ) or 3 (SEQ) with `hready` high.
- R4: Fixed-length bursts use these `hburst` codes: 0 single, 2/3 four beats, 4/5 eight beats, 6/7 sixteen beats. Their last completed beat gives a point. Every completed single transfer gives one. The beat index is 0 on a NONSEQ beat, and each completed SEQ beat is one more than the beat before it.
- R5: In an INCR burst (`hburst` = 1) with `beat_limit` 0, or any of 5 to 7, no beat gives a point, except through the slot budget (R9).
- R6: In an INCR burst with `beat_limit` = 1, every completed beat gives a point.
- R7: In an INCR burst, `beat_limit` = 2, 3 and 4 give a point on each completed beat whose index is 3 mod 4, 7 mod 8 and 15 mod 16 respectively.
- R8: For fixed-length bursts `beat_limit` has no effect. Only the last beat gives a point.
- R9: A completed NONSEQ beat arms the budget from `slot_limit` = L (L > 0). From L cycles after that beat onward, any completed SEQ beat gives a point. A SEQ cycle with `hready` low gives none.
- R10: `slot_limit` = 0 at the NONSEQ beat disables the budget for that burst. An idle cycle disarms it.
- R11: The output is registered. `arb_point` in cycle t+1 is the OR of the R2, R4 to R9 conditions in cycle t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| htrans | input | 2 | Transfer type: 0 idle, 1 busy, 2 NONSEQ, 3 SEQ |
| hburst | input | 3 | Burst type code (R4) |
| hready | input | 1 | Beat completes when high |
| beat_limit | input | 3 | Current master's INCR boundary code (R5 to R7) |
| slot_limit | input | SLOT_W | Slave's cycle budget, 0 disables |
| arb_point | output | 1 | Registered re-arbitration pulse |

## Verification
Directed bursts cover each fixed burst type with a limit code that would fire early if it leaked through. INCR bursts longer than sixteen beats run under every limit code, which separates off-by-one boundary errors from wrong modulus selection. Wait states and busy cycles are inserted inside bursts. These show that neither the beat index nor the point depends on incomplete cycles. Slot budgets are placed just below, at and above the burst length, which exposes a load value off by one cycle.

// File: rtl/brpg_pkg.sv
package brpg_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'd0,
    BU_INCR   = 3'd1,
    BU_WRAP4  = 3'd2,
    BU_INCR4  = 3'd3,
    BU_WRAP8  = 3'd4,
    BU_INCR8  = 3'd5,
    BU_WRAP16 = 3'd6,
    BU_INCR16 = 3'd7
  } burst_e;

  localparam logic [2:0] LIM_INF = 3'd0;
  localparam logic [2:0] LIM_1   = 3'd1;
  localparam logic [2:0] LIM_4   = 3'd2;
  localparam logic [2:0] LIM_8   = 3'd3;
  localparam logic [2:0] LIM_16  = 3'd4;

  // number of boundary codes beyond the one-beat code (4, 8, 16)
  localparam int unsigned N_BOUND = 3;
endpackage

// File: rtl/rearb_beat_track.sv
module rearb_beat_track
  import brpg_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       trans,
  input  logic             ready,
  output logic             beat_done,
  output logic [CNT_W-1:0] beat_idx
);
  logic [CNT_W-1:0] cnt_q;

  assign beat_done = ready && ((trans == TR_NONSEQ) || (trans == TR_SEQ));
  assign beat_idx  = (trans == TR_NONSEQ) ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (trans == TR_IDLE) begin
      cnt_q <= '0;
    end else if (beat_done) begin
      cnt_q <= beat_idx + 1'b1;
    end
  end

  // R4: a completed NONSEQ beat restarts the index so the next beat is 1
  p_cnt_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (trans == TR_NONSEQ && ready) |=> (cnt_q == CNT_W'(1)));

  // R3: incomplete or busy cycles leave the index untouched
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((trans == TR_BUSY) || (trans == TR_SEQ && !ready)) |=> $stable(cnt_q));
endmodule

// File: rtl/rearb_end_detect.sv
module rearb_end_detect
  import brpg_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic [2:0]       burst,
  input  logic [2:0]       limit,
  input  logic             beat_done,
  input  logic [CNT_W-1:0] beat_idx,
  output logic             burst_end
);
  logic [N_BOUND-1:0] bound_hit;
  logic [CNT_W-1:0]   last_idx;

  // boundary k covers 2^(k+2) beats: low k+2 index bits all ones
  for (genvar k = 0; k < N_BOUND; k++) begin : g_bound
    assign bound_hit[k] = &beat_idx[k+1:0];
  end

  always_comb begin
    unique case (burst)
      BU_WRAP4, BU_INCR4:   last_idx = CNT_W'(3);
      BU_WRAP8, BU_INCR8:   last_idx = CNT_W'(7);
      BU_WRAP16, BU_INCR16: last_idx = CNT_W'(15);
      default:              last_idx = '0;
    endcase
  end

  always_comb begin
    burst_end = 1'b0;
    if (beat_done) begin
      if (burst == BU_SINGLE) begin
        burst_end = 1'b1;
      end else if (burst == BU_INCR) begin
        unique case (limit)
          LIM_1:   burst_end = 1'b1;
          LIM_4:   burst_end = bound_hit[0];
          LIM_8:   burst_end = bound_hit[1];
          LIM_16:  burst_end = bound_hit[2];
          default: burst_end = 1'b0;
        endcase
      end else begin
        burst_end = (beat_idx == last_idx);
      end
    end
  end
endmodule

// File: rtl/rearb_slot_timer.sv
module rearb_slot_timer
  import brpg_pkg::*;
#(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        trans,
  input  logic              ready,
  input  logic [SLOT_W-1:0] slot_limit,
  output logic              expired
);
  logic              load;
  logic [SLOT_W-1:0] slot_cnt_q;
  logic              armed_q;

  assign load    = (trans == TR_NONSEQ) && ready;
  assign expired = armed_q && (slot_cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt_q <= '0;
      armed_q    <= 1'b0;
    end else begin
      if (load) begin
        slot_cnt_q <= (slot_limit == '0) ? '0 : slot_limit - 1'b1;
      end else if (slot_cnt_q != '0) begin
        slot_cnt_q <= slot_cnt_q - 1'b1;
      end
      if (trans == TR_IDLE) begin
        armed_q <= 1'b0;
      end else if (load) begin
        armed_q <= (slot_limit != '0);
      end
    end
  end

  // R9: the budget counts down one per cycle between loads
  p_slot_dec_r9: assert property (@(posedge clk) disable iff (rst)
    (slot_cnt_q != '0 && !load) |=> (slot_cnt_q == SLOT_W'($past(slot_cnt_q) - 1'b1)));

  // R10: the counter never wraps below zero
  p_slot_floor_r10: assert property (@(posedge clk) disable iff (rst)
    (slot_cnt_q == '0 && !load) |=> (slot_cnt_q == '0));

  // R10: a zero budget at the burst start never expires
  p_slot_off_r10: assert property (@(posedge clk) disable iff (rst)
    (load && slot_limit == '0) |=> !expired);
endmodule

// File: rtl/rearb_point_gen.sv
module rearb_point_gen
  import brpg_pkg::*;
#(
  parameter int unsigned MAX_BEATS = 16,
  parameter int unsigned SLOT_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic              hready,
  input  logic [2:0]        beat_limit,
  input  logic [SLOT_W-1:0] slot_limit,
  output logic              arb_point
);
  localparam int unsigned CNT_W = $clog2(MAX_BEATS);

  logic             beat_done;
  logic [CNT_W-1:0] beat_idx;
  logic             burst_end;
  logic             slot_expired;
  logic             slot_end;
  logic             point_d;

  rearb_beat_track #(.CNT_W(CNT_W)) u_beats (
    .clk       (clk),
    .rst       (rst),
    .trans     (htrans),
    .ready     (hready),
    .beat_done (beat_done),
    .beat_idx  (beat_idx)
  );

  rearb_end_detect #(.CNT_W(CNT_W)) u_end (
    .burst     (hburst),
    .limit     (beat_limit),
    .beat_done (beat_done),
    .beat_idx  (beat_idx),
    .burst_end (burst_end)
  );

  rearb_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .trans      (htrans),
    .ready      (hready),
    .slot_limit (slot_limit),
    .expired    (slot_expired)
  );

  assign slot_end = slot_expired && (htrans == TR_SEQ) && hready;
  assign point_d  = (htrans == TR_IDLE) || burst_end || slot_end;

  always_ff @(posedge clk) begin
    if (rst) arb_point <= 1'b0;
    else     arb_point <= point_d;
  end

  // R2: idle bus is always an arbitration point
  p_idle_point_r2: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_IDLE) |=> arb_point);

  // R3: no completed beat and not idle -> no point
  p_no_beat_r3: assert property (@(posedge clk) disable iff (rst)
    (htrans != TR_IDLE && !(hready && htrans[1])) |=> !arb_point);

  // R4: each completed single transfer ends its burst
  p_single_r4: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_NONSEQ && hready && hburst == BU_SINGLE) |=> arb_point);

  // R6: one-beat limit breaks at every completed INCR beat
  p_incr_each_r6: assert property (@(posedge clk) disable iff (rst)
    (htrans[1] && hready && hburst == BU_INCR && beat_limit == LIM_1) |=> arb_point);
endmodule

// File: tb/rearb_point_gen_bench.sv
`timescale 1ns/1ps
module rearb_point_gen_bench;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    htrans = 2'd0;
  logic [2:0]    hburst = 3'd0;
  logic          hready = 1'b1;
  logic [2:0]    beat_limit = 3'd0;
  logic [SW-1:0] slot_limit = '0;
  logic          arb_point;

  int    checks = 0;
  int    fails  = 0;
  int    m_cnt = 0;
  int    m_elapsed = 0;
  int    m_len = 0;
  bit    m_armed = 1'b0;
  bit    exp_pt = 1'b0;
  string prev_tag = "R1";

  always #4 clk = ~clk;

  rearb_point_gen #(.MAX_BEATS(16), .SLOT_W(SW)) u_rearb_point_gen (
    .clk(clk), .rst(rst), .htrans(htrans), .hburst(hburst), .hready(hready),
    .beat_limit(beat_limit), .slot_limit(slot_limit), .arb_point(arb_point)
  );

  function automatic int flen(input logic [2:0] hb);
    case (hb)
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      3'd6, 3'd7: return 16;
      default:    return 1;
    endcase
  endfunction

  // expected point from the requirements, given the model state
  function automatic bit model_point(input logic [1:0] tr, input logic [2:0] hb,
                                     input logic rdy, input logic [2:0] lim);
    bit done;
    int idx;
    bit pt;
    if (tr == 2'd0) return 1'b1;
    done = rdy && (tr == 2'd2 || tr == 2'd3);
    if (!done) return 1'b0;
    idx = (tr == 2'd2) ? 0 : m_cnt;
    pt = 1'b0;
    if (hb == 3'd0) pt = 1'b1;
    else if (hb == 3'd1) begin
      case (lim)
        3'd1: pt = 1'b1;
        3'd2: pt = (idx % 4) == 3;
        3'd3: pt = (idx % 8) == 7;
        3'd4: pt = (idx % 16) == 15;
        default: pt = 1'b0;
      endcase
    end else pt = (idx == flen(hb) - 1);
    if (tr == 2'd3 && m_armed && m_elapsed >= m_len) pt = 1'b1;
    return pt;
  endfunction

  task automatic model_update(input logic [1:0] tr, input logic rdy, input logic [SW-1:0] sl);
    bit done;
    done = rdy && (tr == 2'd2 || tr == 2'd3);
    if (tr == 2'd0) m_cnt = 0;
    else if (done && tr == 2'd2) m_cnt = 1;
    else if (done) m_cnt = (m_cnt + 1) % 16;
    if (tr == 2'd2 && rdy) begin
      m_len = int'(sl);
      m_armed = (sl != '0);
      m_elapsed = 1;
    end else if (m_elapsed < 100000) m_elapsed++;
    if (tr == 2'd0) m_armed = 1'b0;
  endtask

  task automatic step(input logic [1:0] tr, input logic [2:0] hb, input logic rdy,
                      input logic [2:0] lim, input logic [SW-1:0] sl, input string tag);
    @(negedge clk);
    checks++;
    if (arb_point !== exp_pt) begin
      fails++;
      $display("FAIL %s arb_point actual=%0b expected=%0b", prev_tag, arb_point, exp_pt);
    end
    rst = 1'b0;
    htrans = tr; hburst = hb; hready = rdy; beat_limit = lim; slot_limit = sl;
    exp_pt = model_point(tr, hb, rdy, lim);
    model_update(tr, rdy, sl);
    prev_tag = tag;
  endtask

  task automatic do_burst(input logic [2:0] hb, input logic [2:0] lim, input logic [SW-1:0] sl,
                          input int beats, input int wait_pct, input int busy_pct, input string tag);
    for (int i = 0; i < beats; i++) begin
      logic [1:0] tr;
      tr = (i == 0) ? 2'd2 : 2'd3;
      if (i > 0 && int'($urandom_range(99)) < busy_pct) step(2'd1, hb, 1'b1, lim, sl, tag);
      while (int'($urandom_range(99)) < wait_pct) step(tr, hb, 1'b0, lim, sl, tag);
      step(tr, hb, 1'b1, lim, sl, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (arb_point !== 1'b0) begin
      fails++;
      $display("FAIL R1 arb_point in reset actual=%0b expected=0", arb_point);
    end
    // first step: checks post-reset value (R1) and releases reset
    step(2'd0, 3'd0, 1'b1, 3'd0, '0, "R2");
    step(2'd0, 3'd0, 1'b0, 3'd0, '0, "R2");
    // R4 singles and fixed bursts, limit code set to something that would leak (R8)
    do_burst(3'd0, 3'd1, '0, 1, 0, 0, "R4");
    do_burst(3'd0, 3'd0, '0, 1, 0, 0, "R4");
    do_burst(3'd3, 3'd0, '0, 4, 0, 0, "R4");
    do_burst(3'd4, 3'd2, '0, 8, 0, 0, "R8");
    do_burst(3'd7, 3'd1, '0, 16, 0, 0, "R8");
    do_burst(3'd2, 3'd3, '0, 4, 30, 30, "R4");
    // R5 infinite and out-of-range codes
    do_burst(3'd1, 3'd0, '0, 20, 0, 0, "R5");
    do_burst(3'd1, 3'd6, '0, 20, 0, 0, "R5");
    // R6 one-beat
    do_burst(3'd1, 3'd1, '0, 5, 0, 0, "R6");
    // R7 boundaries
    do_burst(3'd1, 3'd2, '0, 20, 0, 0, "R7");
    do_burst(3'd1, 3'd3, '0, 20, 0, 0, "R7");
    do_burst(3'd1, 3'd4, '0, 34, 0, 0, "R7");
    // R3 waits and busy cycles in the middle of bursts
    do_burst(3'd1, 3'd1, '0, 8, 50, 50, "R3");
    do_burst(3'd1, 3'd2, '0, 12, 50, 50, "R3");
    // R9 slot budget below, at and above burst length
    do_burst(3'd1, 3'd0, 8'd3, 10, 0, 0, "R9");
    step(2'd0, 3'd0, 1'b1, 3'd0, '0, "R2");
    do_burst(3'd5, 3'd0, 8'd7, 8, 0, 0, "R9");
    do_burst(3'd1, 3'd0, 8'd1, 6, 40, 20, "R9");
    do_burst(3'd1, 3'd0, 8'd12, 10, 0, 0, "R9");
    // R10 disabled budget, then disarm by idle
    do_burst(3'd1, 3'd0, 8'd0, 30, 0, 0, "R10");
    do_burst(3'd1, 3'd0, 8'd2, 1, 0, 0, "R10");
    step(2'd0, 3'd1, 1'b1, 3'd0, 8'd2, "R10");
    step(2'd3, 3'd1, 1'b1, 3'd0, 8'd2, "R10");
    step(2'd3, 3'd1, 1'b1, 3'd0, 8'd2, "R10");
    step(2'd3, 3'd1, 1'b1, 3'd0, 8'd2, "R10");
    // R11 constrained random bursts
    for (int b = 0; b < 300; b++) begin
      logic [2:0] hb;
      logic [2:0] lim;
      logic [SW-1:0] sl;
      int n;
      hb  = 3'($urandom_range(7));
      lim = 3'($urandom_range(7));
      sl  = SW'($urandom_range(12));
      n   = (hb == 3'd1) ? int'($urandom_range(1, 40)) : flen(hb);
      do_burst(hb, lim, sl, n, 20, 15, "R11");
      for (int k = 0; k < int'($urandom_range(2)); k++) step(2'd0, hb, 1'b1, lim, sl, "R11");
    end
    step(2'd0, 3'd0, 1'b1, 3'd0, '0, "R11");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule